// File: doc/BRIEF.md
# Latched Thermal Trip Monitor

This block watches a digital junction-temperature code and protects the die from overheating. Each time the valid strobe is high, the block compares the code with one fixed trip level. A code at or above that level sets a latched fault. The fault drives an active-low trip pin and an active-high request to halt execution. No later reading can clear the fault, however cool. Only reset clears it. The comparison has no hysteresis: the trip level is the only decision point. The block does not model the analog sensor, the diode interface or any temperature conversion.

The controller has three states, held in one register:
- `ST_WAIT` is entered at reset. No valid reading has arrived yet.
- `ST_WATCH` means at least one cool reading has been taken.
- `ST_TRIPPED` is the latched fault.

The transitions are:
- `WAIT->WATCH` on a cool reading.
- `WAIT->TRIPPED` and `WATCH->TRIPPED` on a hot reading.
- `TRIPPED->TRIPPED` on anything, until reset.
- Any state goes to `ST_WAIT` on reset.

After reset is released, the monitor acts on the very first valid reading. If the die is still hot, it trips again at once. If the die has cooled, execution may continue.

Top module: `therm_trip_guard`

## Requirements
- R1: While reset is asserted, and after release until the first valid reading, trip_n is 1, halt_req is 0 and monitor_live is 0.
- R2: A valid reading whose code (8-bit unsigned, degrees Celsius) is below TRIP_LEVEL (default 135) sets monitor_live to 1 at that clock edge. trip_n stays 1 and halt_req stays 0.
- R3: A valid reading equal to TRIP_LEVEL drives trip_n to 0 and halt_req to 1 at the clock edge that samples it.
- R4: A valid reading above TRIP_LEVEL (for example TRIP_LEVEL+1) trips in the same way as R3.
- R5: While temp_valid is 0 the code is ignored, even a code of 255. All three outputs keep their values.
- R6: Once tripped, trip_n stays 0 and halt_req stays 1 for any later reading, including readings well below TRIP_LEVEL.
- R7: Asserting reset clears a trip. If the first valid reading after release is below TRIP_LEVEL, the outputs become trip_n=1, halt_req=0, monitor_live=1.
- R8: If a valid reading at or above TRIP_LEVEL is present at the first clock edge after reset release, the block trips again at that edge.
- R9: trip_n always equals the inverse of halt_req. monitor_live is 0 whenever halt_req is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every output changes only on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; the only way to clear a trip |
| temp_code | input | 8 | Junction temperature, unsigned degrees Celsius |
| temp_valid | input | 1 | High when temp_code holds a reading to sample |
| trip_n | output | 1 | Active-low latched thermal trip pin |
| halt_req | output | 1 | Active-high latched request to stop execution |
| monitor_live | output | 1 | High once a cool reading has been taken and no trip is latched |

## Verification
Two events can fall on the same clock edge: reset release and the first hot sample. The bench provokes this by holding a valid reading at or above the trip level while reset is low. It then releases reset at a falling edge, so that the very next rising edge both leaves reset and samples the hot code. The design passes only if the outputs read trip_n=0 and halt_req=1 one cycle after release. A cool reading held through the same release must instead give monitor_live=1.

// File: rtl/thermtrip_pkg.sv
package thermtrip_pkg;

    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_WATCH   = 2'd1,
        ST_TRIPPED = 2'd2
    } trip_state_t;

endpackage

// File: rtl/trip_compare.sv
module trip_compare #(
    parameter int CODE_W     = 8,
    parameter int TRIP_LEVEL = 135
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              valid_i,
    output logic              hot_o,
    output logic              cool_o
);
    localparam logic [CODE_W-1:0] LEVEL_C = CODE_W'(TRIP_LEVEL);

    logic at_or_above;

    generate
        if (TRIP_LEVEL <= 0) begin : g_always_hot
            assign at_or_above = 1'b1;
        end else begin : g_compare
            assign at_or_above = (code_i >= LEVEL_C);
        end
    endgenerate

    assign hot_o  = valid_i & at_or_above;
    assign cool_o = valid_i & ~at_or_above;

endmodule

// File: rtl/trip_fsm.sv
module trip_fsm
    import thermtrip_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hot_i,
    input  logic        cool_i,
    output trip_state_t state_q,
    output trip_state_t state_d
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (hot_i)       state_d = ST_TRIPPED;
                else if (cool_i) state_d = ST_WATCH;
            end
            ST_WATCH: begin
                if (hot_i) state_d = ST_TRIPPED;
            end
            ST_TRIPPED: state_d = ST_TRIPPED;
            default:    state_d = ST_TRIPPED;
        endcase
    end

    // R6
    tripped_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_TRIPPED |=> state_q == ST_TRIPPED);

    // R3
    hot_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hot_i |=> state_q == ST_TRIPPED);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot_i && !cool_i) |=> state_q == $past(state_q));

    // R2
    cool_watch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cool_i && state_q != ST_TRIPPED) |=> state_q == ST_WATCH);

endmodule

// File: rtl/trip_outputs.sv
module trip_outputs
    import thermtrip_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  trip_state_t state_d,
    output logic        trip_n_o,
    output logic        halt_o,
    output logic        live_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trip_n_o <= 1'b1;
            halt_o   <= 1'b0;
            live_o   <= 1'b0;
        end else begin
            trip_n_o <= (state_d != ST_TRIPPED);
            halt_o   <= (state_d == ST_TRIPPED);
            live_o   <= (state_d == ST_WATCH);
        end
    end

    // R9
    pin_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip_n_o != halt_o);

    // R9
    live_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> !live_o);

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);

endmodule

// File: rtl/therm_trip_guard.sv
module therm_trip_guard
    import thermtrip_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int TRIP_LEVEL = 135
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] temp_code,
    input  logic              temp_valid,
    output logic              trip_n,
    output logic              halt_req,
    output logic              monitor_live
);

    logic        hot;
    logic        cool;
    trip_state_t state_q;
    trip_state_t state_d;

    trip_compare #(
        .CODE_W     (CODE_W),
        .TRIP_LEVEL (TRIP_LEVEL)
    ) u_cmp (
        .code_i  (temp_code),
        .valid_i (temp_valid),
        .hot_o   (hot),
        .cool_o  (cool)
    );

    trip_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hot_i   (hot),
        .cool_i  (cool),
        .state_q (state_q),
        .state_d (state_d)
    );

    trip_outputs u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_d  (state_d),
        .trip_n_o (trip_n),
        .halt_o   (halt_req),
        .live_o   (monitor_live)
    );

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (trip_n && !halt_req && !monitor_live));

endmodule

// File: tb/sim_therm_trip_guard.sv
`timescale 1ns/1ps
module sim_therm_trip_guard;

    localparam int LEVEL = 135;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] temp_code;
    logic       temp_valid;
    logic       trip_n;
    logic       halt_req;
    logic       monitor_live;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    therm_trip_guard #(.CODE_W(8), .TRIP_LEVEL(LEVEL)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .temp_code    (temp_code),
        .temp_valid   (temp_valid),
        .trip_n       (trip_n),
        .halt_req     (halt_req),
        .monitor_live (monitor_live)
    );

    task automatic chk_out(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {trip_n, halt_req, monitor_live};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s {trip_n,halt_req,live} actual=%b expected=%b", req, act, exp);
        end
        checks++;
        if (trip_n === halt_req) begin
            failures++;
            $display("FAIL R9 pin pair actual=%b%b expected=complementary", trip_n, halt_req);
        end
    endtask

    task automatic sample(input logic v, input logic [7:0] c, input string req,
                          input logic [2:0] exp);
        @(negedge clk);
        temp_valid = v;
        temp_code  = c;
        @(negedge clk);
        chk_out(req, exp);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        temp_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk_out("R1 in reset", 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk_out("R1 after release", 3'b100);
    endtask

    task automatic t_ignore_before_live();
        sample(1'b0, 8'd250, "R5 hot code without valid", 3'b100);
    endtask

    task automatic t_cool_reading();
        sample(1'b1, 8'(LEVEL-1), "R2 one below level", 3'b101);
        sample(1'b0, 8'd255, "R5 invalid 255 while live", 3'b101);
        sample(1'b1, 8'd20, "R2 low reading", 3'b101);
    endtask

    task automatic t_at_threshold();
        sample(1'b1, 8'(LEVEL), "R3 exactly at level", 3'b010);
    endtask

    task automatic t_latch_hold();
        sample(1'b1, 8'd25, "R6 cold reading after trip", 3'b010);
        sample(1'b1, 8'(LEVEL-1), "R6 just below level after trip", 3'b010);
        sample(1'b0, 8'd0, "R6 no reading after trip", 3'b010);
    endtask

    task automatic t_reset_clear(input logic [7:0] c, input string req,
                                 input logic [2:0] exp);
        @(negedge clk);
        rst_n = 1'b0;
        temp_valid = 1'b1;
        temp_code  = c;
        @(negedge clk);
        chk_out("R7 reset clears trip", 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk_out(req, exp);
    endtask

    task automatic t_above_threshold();
        sample(1'b1, 8'(LEVEL+1), "R4 one above level", 3'b010);
    endtask

    initial begin
        rst_n = 1'b0;
        temp_valid = 1'b0;
        temp_code = 8'd0;
        t_reset_state();
        t_ignore_before_live();
        t_cool_reading();
        t_at_threshold();
        t_latch_hold();
        t_reset_clear(8'd40, "R7 cool after release", 3'b101);
        t_above_threshold();
        t_latch_hold();
        t_reset_clear(8'(LEVEL+1), "R8 retrip above level on release", 3'b010);
        t_reset_clear(8'(LEVEL), "R8 retrip at level on release", 3'b010);
        t_reset_clear(8'(LEVEL-1), "R7 release just below level", 3'b101);
        sample(1'b1, 8'd255, "R4 max code", 3'b010);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule